// File: doc/BRIEF.md
# ALU Status Flag Register

This block is the 8-bit status register of a small processor core. It holds three program page-select bits, two power-state flags (a watchdog time-out flag and a power-down flag), and three arithmetic flags: zero, digit carry and carry. Each cycle the ALU reports an operation class together with its result and adder carries. The block turns these into flag values and updates only the flags that the operation class affects.

Software sees the register as an ordinary file register and writes it through a byte write port. The two power-state flags cannot be written this way. Three instruction events from outside the block control them: a watchdog clear, a sleep entry and a watchdog expiry. When the chained-carry option is selected, the register also drives the current carry flag back into the adder as its carry-in.

Top module: `status_flag_reg`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) leaves `status` at 8'h18: page bits 000, time-out and power-down flags 1, and zero, digit-carry and carry flags 0.
- R2: The field layout of `status` is bits 7:5 page select, bit 4 time-out flag, bit 3 power-down flag, bit 2 zero (Z), bit 1 digit carry (DC), bit 0 carry (C). A write (`wr_en` high) loads bits 7:5 and 2:0 from `wr_data` in the following cycle.
- R3: A write has no effect on bits 4 and 3 of `status`, whatever values `wr_data` holds in those bits.
- R4: The time-out flag goes to 0 the cycle after `wdt_expire`. It goes to 1 the cycle after `wdt_clear` or `sleep_enter`. If `wdt_expire` is high in the same cycle as either of the other two events, the flag goes to 0.
- R5: The power-down flag goes to 1 the cycle after `wdt_clear` and to 0 the cycle after `sleep_enter`. If both are high in the same cycle, the flag goes to 0.
- R6: Add (`alu_op` = 1) sets C to `alu_cy7` (carry out of bit 7), DC to `alu_cy3` (carry out of bit 3), and Z to 1 exactly when `alu_result` is zero.
- R7: Subtract (`alu_op` = 2) treats `alu_cy7` and `alu_cy3` as borrows. It sets C and DC to their inverses, so each flag is 1 when no borrow occurred. Z is set from `alu_result` as for add.
- R8: Rotate right (`alu_op` = 3) loads C from `alu_src_lsb`. Rotate left (`alu_op` = 4) loads C from `alu_src_msb`. Neither changes Z or DC.
- R9: A logical or move operation (`alu_op` = 5) sets Z from `alu_result` and leaves DC and C unchanged.
- R10: When a write and a flag-updating operation occur in the same cycle, each flag that the operation updates takes the ALU value. The page bits, and any flag the operation does not touch, take the written value.
- R11: `carry_in` equals the current C flag when `cin_opt_n` is 0 and `alu_op` is add or subtract. Otherwise it is 0.
- R12: Operation codes 0, 6 and 7 change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Software write strobe for the register |
| wr_data | input | 8 | Byte written by software |
| alu_op | input | 3 | Operation class: 0 none, 1 add, 2 subtract, 3 rotate right, 4 rotate left, 5 logical/move |
| alu_result | input | 8 | Result byte of the current operation |
| alu_cy7 | input | 1 | Adder carry (add) or borrow (subtract) out of bit 7 |
| alu_cy3 | input | 1 | Adder carry (add) or borrow (subtract) out of bit 3 |
| alu_src_lsb | input | 1 | Bit 0 of the operand being rotated |
| alu_src_msb | input | 1 | Bit 7 of the operand being rotated |
| wdt_clear | input | 1 | Watchdog-clear instruction event |
| sleep_enter | input | 1 | Sleep instruction event |
| wdt_expire | input | 1 | Watchdog time-out event |
| cin_opt_n | input | 1 | Chained-carry option, active low |
| status | output | 8 | Register contents |
| carry_in | output | 1 | Carry-in to the adder |

## Verification
The assertions assume that every input holds a known value after reset. They also assume that `alu_cy7` and `alu_cy3` matter only in add and subtract cycles. No assertion relies on the power events being exclusive, because the block defines a priority among them. The stimulus computes result and carry bits from real 8-bit sums and differences, using the carry-in the block supplies. This keeps the arithmetic inputs consistent with one another. Most power events arrive alone, and a few directed cycles combine them on purpose to reach the priority rules.

// File: rtl/status_pkg.sv
package status_pkg;

    localparam int unsigned PAGE_W   = 3;
    localparam int unsigned STATUS_W = 8;
    localparam int unsigned N_ARITH  = 3;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_ADD   = 3'd1,
        OP_SUB   = 3'd2,
        OP_ROR   = 3'd3,
        OP_ROL   = 3'd4,
        OP_LOGIC = 3'd5,
        OP_RSV6  = 3'd6,
        OP_RSV7  = 3'd7
    } alu_op_e;

    // arithmetic flags, packed so that bit 2 = Z, bit 1 = DC, bit 0 = C
    typedef struct packed {
        logic z;
        logic dc;
        logic c;
    } arith_flags_t;

    // whole register image in its bit order
    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic              to;
        logic              pd;
        arith_flags_t      ar;
    } status_t;

    localparam status_t STATUS_RST = '{page: '0, to: 1'b1, pd: 1'b1,
                                       ar: '{z: 1'b0, dc: 1'b0, c: 1'b0}};

    // which arithmetic flags an operation class writes
    function automatic arith_flags_t op_update_mask(alu_op_e op);
        arith_flags_t m;
        m = '{z: 1'b0, dc: 1'b0, c: 1'b0};
        case (op)
            OP_ADD, OP_SUB: m = '{z: 1'b1, dc: 1'b1, c: 1'b1};
            OP_ROR, OP_ROL: m.c = 1'b1;
            OP_LOGIC:       m.z = 1'b1;
            default:        m = '{z: 1'b0, dc: 1'b0, c: 1'b0};
        endcase
        return m;
    endfunction

    function automatic logic uses_adder_cin(alu_op_e op);
        return (op == OP_ADD) || (op == OP_SUB);
    endfunction

endpackage

// File: rtl/status_flag_eval.sv
module status_flag_eval
    import status_pkg::*;
(
    input  alu_op_e                 op,
    input  logic [STATUS_W-1:0]     result,
    input  logic                    cy7,
    input  logic                    cy3,
    input  logic                    src_lsb,
    input  logic                    src_msb,
    output arith_flags_t            upd,
    output arith_flags_t            val
);
    logic res_zero;

    assign res_zero = (result == '0);

    always_comb begin
        upd = op_update_mask(op);
        val = '{z: res_zero, dc: 1'b0, c: 1'b0};
        case (op)
            OP_ADD: begin
                val.c  = cy7;
                val.dc = cy3;
            end
            OP_SUB: begin
                // inverted-borrow convention
                val.c  = ~cy7;
                val.dc = ~cy3;
            end
            OP_ROR:  val.c = src_lsb;
            OP_ROL:  val.c = src_msb;
            default: val.c = 1'b0;
        endcase
    end

endmodule

// File: rtl/status_power_bits.sv
module status_power_bits (
    input  logic clk,
    input  logic rst,
    input  logic wdt_clear,
    input  logic sleep_enter,
    input  logic wdt_expire,
    output logic to_q,
    output logic pd_q
);
    always_ff @(posedge clk) begin
        if (rst)                          to_q <= 1'b1;
        else if (wdt_expire)              to_q <= 1'b0;
        else if (wdt_clear || sleep_enter) to_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)              pd_q <= 1'b1;
        else if (sleep_enter) pd_q <= 1'b0;
        else if (wdt_clear)   pd_q <= 1'b1;
    end

    assert_to_expire_R4: assert property (@(posedge clk) disable iff (rst)
        wdt_expire |=> !to_q);
    assert_to_set_R4: assert property (@(posedge clk) disable iff (rst)
        (!wdt_expire && (wdt_clear || sleep_enter)) |=> to_q);
    assert_pd_sleep_R5: assert property (@(posedge clk) disable iff (rst)
        sleep_enter |=> !pd_q);
    assert_pd_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (wdt_clear && !sleep_enter) |=> pd_q);

endmodule

// File: rtl/status_arith_bits.sv
module status_arith_bits
    import status_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  arith_flags_t wr_val,
    input  arith_flags_t upd,
    input  arith_flags_t val,
    output arith_flags_t q
);
    logic [N_ARITH-1:0] wr_v, upd_v, val_v, q_v;

    assign wr_v  = wr_val;
    assign upd_v = upd;
    assign val_v = val;
    assign q     = q_v;

    for (genvar i = 0; i < N_ARITH; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)           q_v[i] <= 1'b0;
            else if (upd_v[i]) q_v[i] <= val_v[i];
            else if (wr_en)    q_v[i] <= wr_v[i];
        end

        assert_alu_over_write_R10: assert property (@(posedge clk) disable iff (rst)
            upd_v[i] |=> (q_v[i] == $past(val_v[i])));
        assert_write_untouched_R10: assert property (@(posedge clk) disable iff (rst)
            (wr_en && !upd_v[i]) |=> (q_v[i] == $past(wr_v[i])));
    end

endmodule

// File: rtl/status_flag_reg.sv
module status_flag_reg
    import status_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic [2:0] alu_op,
    input  logic [7:0] alu_result,
    input  logic       alu_cy7,
    input  logic       alu_cy3,
    input  logic       alu_src_lsb,
    input  logic       alu_src_msb,
    input  logic       wdt_clear,
    input  logic       sleep_enter,
    input  logic       wdt_expire,
    input  logic       cin_opt_n,
    output logic [7:0] status,
    output logic       carry_in
);
    alu_op_e           op_cur;
    status_t           wr_view;
    status_t           st;
    arith_flags_t      upd, val, ar_q;
    logic [PAGE_W-1:0] page_q;
    logic              to_q, pd_q;

    assign op_cur  = alu_op_e'(alu_op);
    assign wr_view = status_t'(wr_data);

    status_flag_eval u_eval (
        .op      (op_cur),
        .result  (alu_result),
        .cy7     (alu_cy7),
        .cy3     (alu_cy3),
        .src_lsb (alu_src_lsb),
        .src_msb (alu_src_msb),
        .upd     (upd),
        .val     (val)
    );

    status_power_bits u_power (
        .clk         (clk),
        .rst         (rst),
        .wdt_clear   (wdt_clear),
        .sleep_enter (sleep_enter),
        .wdt_expire  (wdt_expire),
        .to_q        (to_q),
        .pd_q        (pd_q)
    );

    status_arith_bits u_arith (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_val (wr_view.ar),
        .upd    (upd),
        .val    (val),
        .q      (ar_q)
    );

    always_ff @(posedge clk) begin
        if (rst)        page_q <= STATUS_RST.page;
        else if (wr_en) page_q <= wr_view.page;
    end

    assign st       = '{page: page_q, to: to_q, pd: pd_q, ar: ar_q};
    assign status   = st;
    assign carry_in = (!cin_opt_n && uses_adder_cin(op_cur)) ? ar_q.c : 1'b0;

    assert_reset_value_R1: assert property (@(posedge clk)
        rst |=> (status == 8'h18));
    assert_write_loads_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && op_cur == OP_NONE) |=>
        (status[7:5] == $past(wr_data[7:5]) && status[2:0] == $past(wr_data[2:0])));
    assert_ro_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_data[4] != to_q || wr_data[3] != pd_q)
         && !wdt_clear && !sleep_enter && !wdt_expire) |=>
        ($stable(status[4]) && $stable(status[3])));
    assert_add_flags_R6: assert property (@(posedge clk) disable iff (rst)
        (op_cur == OP_ADD) |=>
        (status[0] == $past(alu_cy7) && status[1] == $past(alu_cy3)
         && status[2] == ($past(alu_result) == 8'h00)));
    assert_sub_flags_R7: assert property (@(posedge clk) disable iff (rst)
        (op_cur == OP_SUB) |=>
        (status[0] == !$past(alu_cy7) && status[1] == !$past(alu_cy3)
         && status[2] == ($past(alu_result) == 8'h00)));
    assert_ror_carry_R8: assert property (@(posedge clk) disable iff (rst)
        (op_cur == OP_ROR && !wr_en) |=>
        (status[0] == $past(alu_src_lsb) && $stable(status[2:1])));
    assert_rol_carry_R8: assert property (@(posedge clk) disable iff (rst)
        (op_cur == OP_ROL && !wr_en) |=>
        (status[0] == $past(alu_src_msb) && $stable(status[2:1])));
    assert_logic_z_R9: assert property (@(posedge clk) disable iff (rst)
        (op_cur == OP_LOGIC && !wr_en) |=>
        (status[2] == ($past(alu_result) == 8'h00) && $stable(status[1:0])));
    assert_cin_off_R11: assert property (@(posedge clk) disable iff (rst)
        cin_opt_n |-> !carry_in);
    assert_idle_ops_R12: assert property (@(posedge clk) disable iff (rst)
        ((op_cur == OP_NONE || op_cur == OP_RSV6 || op_cur == OP_RSV7) && !wr_en) |=>
        $stable(status[2:0]));

endmodule

// File: tb/test_status_flag_reg.sv
module test_status_flag_reg;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en, alu_cy7, alu_cy3, alu_src_lsb, alu_src_msb;
    logic       wdt_clear, sleep_enter, wdt_expire, cin_opt_n;
    logic [7:0] wr_data, alu_result;
    logic [2:0] alu_op;
    logic [7:0] status;
    logic       carry_in;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;
    logic [7:0] m_st;

    always #10 clk = ~clk;

    status_flag_reg i_status_flag_reg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .alu_op(alu_op), .alu_result(alu_result), .alu_cy7(alu_cy7),
        .alu_cy3(alu_cy3), .alu_src_lsb(alu_src_lsb), .alu_src_msb(alu_src_msb),
        .wdt_clear(wdt_clear), .sleep_enter(sleep_enter), .wdt_expire(wdt_expire),
        .cin_opt_n(cin_opt_n), .status(status), .carry_in(carry_in)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // one cycle: drive at negedge, check carry_in, model the edge, check status
    task automatic step(input string tag, input int op, input int a, input int b,
                        input bit wr, input int wd, input bit clr, input bit slp,
                        input bit expi, input bit optn);
        logic [7:0] nx;
        int exp_cin, bin, full, res;
        bit c7, c3;
        exp_cin = (!optn && (op == 1 || op == 2)) ? int'(m_st[0]) : 0;
        res = $urandom_range(255);
        c7  = 1'($urandom_range(1));
        c3  = 1'($urandom_range(1));
        if (op == 1) begin
            full = a + b + exp_cin;
            res  = full & 255;
            c7   = full > 255;
            c3   = ((a & 15) + (b & 15) + exp_cin) > 15;
        end else if (op == 2) begin
            bin = (!optn) ? (1 - exp_cin) : 0;
            res = (a - b - bin) & 255;
            c7  = a < (b + bin);
            c3  = (a & 15) < ((b & 15) + bin);
        end else if (op == 5) begin
            res = a & b;
        end
        wr_en = wr; wr_data = 8'(wd); alu_op = 3'(op); alu_result = 8'(res);
        alu_cy7 = c7; alu_cy3 = c3;
        alu_src_lsb = 1'(a & 1); alu_src_msb = 1'((a >> 7) & 1);
        wdt_clear = clr; sleep_enter = slp; wdt_expire = expi; cin_opt_n = optn;
        #1;
        check({tag, " R11 carry_in"}, {7'd0, carry_in}, 8'(exp_cin));
        nx = m_st;
        if (wr) begin
            nx[7:5] = wr_data[7:5];
            nx[2:0] = wr_data[2:0];
        end
        if (expi) nx[4] = 1'b0;
        else if (clr || slp) nx[4] = 1'b1;
        if (slp) nx[3] = 1'b0;
        else if (clr) nx[3] = 1'b1;
        case (op)
            1: begin nx[0] = c7;  nx[1] = c3;  nx[2] = (res == 0); end
            2: begin nx[0] = !c7; nx[1] = !c3; nx[2] = (res == 0); end
            3: nx[0] = alu_src_lsb;
            4: nx[0] = alu_src_msb;
            5: nx[2] = (res == 0);
            default: ;
        endcase
        m_st = nx;
        @(posedge clk);
        @(negedge clk);
        check({tag, " status"}, status, m_st);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 0; wr_data = 0; alu_op = 0; alu_result = 0;
        alu_cy7 = 0; alu_cy3 = 0; alu_src_lsb = 0; alu_src_msb = 0;
        wdt_clear = 0; sleep_enter = 0; wdt_expire = 0; cin_opt_n = 1;
        repeat (3) @(negedge clk);
        check("R1 reset", status, 8'h18);
        rst = 1'b0;
        m_st = 8'h18;

        step("R2 write ff", 0, 0, 0, 1, 'hFF, 0, 0, 0, 1);
        step("R3 write 00", 0, 0, 0, 1, 'h00, 0, 0, 0, 1);
        step("R4 expire", 0, 0, 0, 0, 0, 0, 0, 1, 1);
        step("R3 write 18 while to=0", 0, 0, 0, 1, 'h18, 0, 0, 0, 1);
        step("R5 sleep", 0, 0, 0, 0, 0, 0, 1, 0, 1);
        step("R4 clear", 0, 0, 0, 0, 0, 1, 0, 0, 1);
        step("R4 expire+clear", 0, 0, 0, 0, 0, 1, 0, 1, 1);
        step("R5 sleep+clear", 0, 0, 0, 0, 0, 1, 1, 0, 1);
        step("R4 sleep sets to", 0, 0, 0, 0, 0, 0, 1, 0, 1);
        step("R6 add ff+01", 1, 'hFF, 'h01, 0, 0, 0, 0, 0, 1);
        step("R6 add 10+20", 1, 'h10, 'h20, 0, 0, 0, 0, 0, 1);
        step("R6 add 0f+01", 1, 'h0F, 'h01, 0, 0, 0, 0, 0, 1);
        step("R7 sub 05-03", 2, 'h05, 'h03, 0, 0, 0, 0, 0, 1);
        step("R7 sub 03-05", 2, 'h03, 'h05, 0, 0, 0, 0, 0, 1);
        step("R7 sub 07-07", 2, 'h07, 'h07, 0, 0, 0, 0, 0, 1);
        step("R7 sub 10-01", 2, 'h10, 'h01, 0, 0, 0, 0, 0, 1);
        step("R2 write 06", 0, 0, 0, 1, 'h06, 0, 0, 0, 1);
        step("R8 ror lsb1", 3, 'h01, 0, 0, 0, 0, 0, 0, 1);
        step("R8 rol msb0", 4, 'h7F, 0, 0, 0, 0, 0, 0, 1);
        step("R8 rol msb1", 4, 'h80, 0, 0, 0, 0, 0, 0, 1);
        step("R9 logic zero", 5, 'hF0, 'h0F, 0, 0, 0, 0, 0, 1);
        step("R9 logic nonzero", 5, 'hF0, 'h30, 0, 0, 0, 0, 0, 1);
        step("R10 write+add", 1, 'hFF, 'h01, 1, 'h00, 0, 0, 0, 1);
        step("R10 write+ror", 3, 'h00, 0, 1, 'hE7, 0, 0, 0, 1);
        step("R10 write+logic", 5, 'h01, 'h01, 1, 'h05, 0, 0, 0, 1);
        step("R11 chain add c=1", 1, 'h01, 'h01, 0, 0, 0, 0, 0, 0);
        step("R11 set c", 0, 0, 0, 1, 'h01, 0, 0, 0, 0);
        step("R11 chain add", 1, 'h01, 'h01, 0, 0, 0, 0, 0, 0);
        step("R11 chain sub", 2, 'h09, 'h04, 0, 0, 0, 0, 0, 0);
        step("R11 option off", 1, 'h01, 'h01, 0, 0, 0, 0, 0, 1);
        step("R12 write 07", 0, 0, 0, 1, 'h07, 0, 0, 0, 1);
        step("R12 op6", 6, 'h00, 0, 0, 0, 0, 0, 0, 1);
        step("R12 op7", 7, 'h00, 0, 0, 0, 0, 0, 0, 1);
        step("R12 op0", 0, 'h00, 0, 0, 0, 0, 0, 0, 0);

        for (int k = 0; k < 3000; k++) begin
            int ev;
            ev = $urandom_range(15);
            step("random", $urandom_range(7), $urandom_range(255), $urandom_range(255),
                 ($urandom_range(3) == 0), $urandom_range(255),
                 (ev == 1 || ev == 4), (ev == 2 || ev == 4), (ev == 3),
                 1'($urandom_range(1)));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule